// File: doc/BRIEF.md
# Push-Button Step Qualifier with Auto-Repeat

This block turns two raw push-button levels, one for stepping a position register up and one for stepping it down, into clean single-cycle step pulses. Each raw level first passes through a two-flop synchronizer. All timing is counted on a free-running tick input, nominally one pulse per millisecond. A press counts only once the button has stayed high without a break for the qualification time, which is 8 ticks by default. Any shorter high pulse is treated as contact bounce and thrown away.

Holding an accepted press past the hold time (1000 ticks by default) switches the channel into auto-scan. In auto-scan a further step is issued every repeat interval (140 ticks by default) for as long as the button stays down. Releasing the button returns the channel to idle at once and clears every counter. A third channel uses the same filter for an active-low store pin. It raises one store request per accepted press and never repeats. If both direction channels are qualified together, no step comes out of either of them.

Top module: `btn_step_ctrl`

## Requirements
- R1: After reset, step_up, step_dn and store_req are all low.
- R2: A direction button that is high for fewer than QUAL_TICKS consecutive ticks produces no step pulse.
- R3: When a direction button has been high for QUAL_TICKS ticks, exactly one step pulse appears on its own output, one clock after that tick. No further step follows before the hold time.
- R4: A press held for HOLD_TICKS ticks enters auto-scan. No pulse is issued on entry, so pulses occur only at ticks QUAL_TICKS and HOLD_TICKS + k*REPEAT_TICKS (k >= 1), counted from the press.
- R5: In auto-scan, one step pulse is issued every REPEAT_TICKS ticks until release. Every step pulse is one clock wide and follows a clock in which tick was high.
- R6: The down button behaves the same as the up button, with its pulses on step_dn.
- R7: store_n is active low. Holding it low for QUAL_TICKS ticks raises store_req for one clock, once per press, with no auto-repeat. A shorter low produces nothing.
- R8: Releasing a button returns its channel to idle and clears its counters. Two short presses separated by a release never add up to a qualification.
- R9: While one direction channel is qualified, step pulses from the other channel are suppressed. Pressing both together yields no steps at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock timing strobe, nominally once per millisecond |
| btn_up | input | 1 | Raw up button, active high |
| btn_dn | input | 1 | Raw down button, active high |
| store_n | input | 1 | Raw manual-store pin, active low |
| step_up | output | 1 | One-clock pulse: increment the position |
| step_dn | output | 1 | One-clock pulse: decrement the position |
| store_req | output | 1 | One-clock pulse: save the position |

## Verification
A channel whose counter is off by one moves a step pulse by one whole tick, which is four clocks in the bench. The scoreboard catches this on the first qualification, because it compares the tick index of each pulse. A channel that does not return to idle on release shows up either as a missing step on the next short press or as a stray scan pulse within one repeat interval. A wrong suppression state appears as a pulse, or a missing pulse, during the overlap and both-pressed presses.

// File: rtl/btn_pkg.sv
`timescale 1ns/1ps
package btn_pkg;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_HELD = 2'd1,
    CH_SCAN = 2'd2
  } chan_state_e;

  // Counter width able to hold the value lim (at least 1 bit)
  function automatic int unsigned cnt_width(int unsigned lim);
    int unsigned w;
    w = $clog2(lim + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // True when a counter at value c reaches lim after this tick
  function automatic logic hits_limit(int unsigned c, int unsigned lim);
    return (c + 1) == lim;
  endfunction

endpackage

// File: rtl/btn_sync2.sv
`timescale 1ns/1ps
module btn_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/btn_qual_chan.sv
`timescale 1ns/1ps
module btn_qual_chan
  import btn_pkg::*;
#(
  parameter int unsigned QUAL_TICKS   = 8,
  parameter int unsigned HOLD_TICKS   = 1000,
  parameter int unsigned REPEAT_TICKS = 140,
  parameter bit          AUTO_REPEAT  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic act,
  output logic step_o,
  output logic qual_o,
  output logic fire_o,
  output logic scan_o
);
  localparam int unsigned CNT_W = cnt_width(HOLD_TICKS);
  localparam int unsigned REP_W = cnt_width(REPEAT_TICKS);

  chan_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             fire;
  logic             scan_allow;

  generate
    if (AUTO_REPEAT) begin : g_scan
      assign scan_allow = 1'b1;
    end else begin : g_noscan
      assign scan_allow = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rep_d   = rep_q;
    fire    = 1'b0;
    if (!act) begin
      state_d = CH_IDLE;
      cnt_d   = '0;
      rep_d   = '0;
    end else if (tick) begin
      unique case (state_q)
        CH_IDLE: begin
          cnt_d = cnt_q + CNT_W'(1);
          if (hits_limit(32'(cnt_q), QUAL_TICKS)) begin
            state_d = CH_HELD;
            fire    = 1'b1;
          end
        end
        CH_HELD: begin
          if (scan_allow) begin
            cnt_d = cnt_q + CNT_W'(1);
            if (hits_limit(32'(cnt_q), HOLD_TICKS)) begin
              state_d = CH_SCAN;
              rep_d   = '0;
            end
          end
        end
        CH_SCAN: begin
          if (hits_limit(32'(rep_q), REPEAT_TICKS)) begin
            fire  = 1'b1;
            rep_d = '0;
          end else begin
            rep_d = rep_q + REP_W'(1);
          end
        end
        default: state_d = CH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      cnt_q   <= '0;
      rep_q   <= '0;
      step_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rep_q   <= rep_d;
      step_o  <= fire;
    end
  end

  assign qual_o = (state_q != CH_IDLE);
  assign scan_o = (state_q == CH_SCAN);
  assign fire_o = fire;
endmodule

// File: rtl/btn_step_ctrl.sv
`timescale 1ns/1ps
module btn_step_ctrl #(
  parameter int unsigned QUAL_TICKS   = 8,
  parameter int unsigned HOLD_TICKS   = 1000,
  parameter int unsigned REPEAT_TICKS = 140
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic btn_up,
  input  logic btn_dn,
  input  logic store_n,
  output logic step_up,
  output logic step_dn,
  output logic store_req
);
  localparam int NDIR = 2;

  logic [NDIR-1:0] dir_raw, dir_act, dir_step, dir_qual, dir_fire, dir_scan;

  // Named internal events for the checker
  logic up_act, up_qual, dn_qual, store_act, store_qual;

  assign dir_raw = {btn_dn, btn_up};

  generate
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
      btn_sync2 #(.RST_VAL(1'b0)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d (dir_raw[d]),
        .q (dir_act[d])
      );
      btn_qual_chan #(
        .QUAL_TICKS  (QUAL_TICKS),
        .HOLD_TICKS  (HOLD_TICKS),
        .REPEAT_TICKS(REPEAT_TICKS),
        .AUTO_REPEAT (1'b1)
      ) u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .act    (dir_act[d]),
        .step_o (dir_step[d]),
        .qual_o (dir_qual[d]),
        .fire_o (dir_fire[d]),
        .scan_o (dir_scan[d])
      );
    end
  endgenerate

  logic store_sync, store_step, store_fire, store_scan;

  btn_sync2 #(.RST_VAL(1'b1)) u_store_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (store_n),
    .q (store_sync)
  );

  assign store_act = ~store_sync;

  btn_qual_chan #(
    .QUAL_TICKS  (QUAL_TICKS),
    .HOLD_TICKS  (QUAL_TICKS + 1),
    .REPEAT_TICKS(REPEAT_TICKS),
    .AUTO_REPEAT (1'b0)
  ) u_store_chan (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .act    (store_act),
    .step_o (store_step),
    .qual_o (store_qual),
    .fire_o (store_fire),
    .scan_o (store_scan)
  );

  assign up_act  = dir_act[0];
  assign up_qual = dir_qual[0];
  assign dn_qual = dir_qual[1];

  // R9: a qualified opposite channel blocks this channel's steps
  assign step_up   = dir_step[0] & ~dir_qual[1];
  assign step_dn   = dir_step[1] & ~dir_qual[0];
  assign store_req = store_step;
endmodule

// File: rtl/btn_step_chk.sv
`timescale 1ns/1ps
module btn_step_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic step_up,
  input logic step_dn,
  input logic store_req,
  input logic up_act,
  input logic up_qual,
  input logic dn_qual,
  input logic store_qual
);
  // R9
  no_both_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));

  // R3
  step_needs_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |-> up_qual);

  // R8
  release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_act |=> !up_qual);

  // R5
  step_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn) |-> $past(tick));

  // R5
  step_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |=> !step_up);

  // R7
  store_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);

  // R7
  store_needs_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> store_qual);

  // R9
  dn_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |-> (dn_qual && !up_qual));
endmodule

bind btn_step_ctrl btn_step_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .step_up    (step_up),
  .step_dn    (step_dn),
  .store_req  (store_req),
  .up_act     (up_act),
  .up_qual    (up_qual),
  .dn_qual    (dn_qual),
  .store_qual (store_qual)
);

// File: tb/sim_btn_step_ctrl.sv
`timescale 1ns/1ps
module sim_btn_step_ctrl;
  localparam int Q = 4;
  localparam int H = 20;
  localparam int RP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic btn_up = 1'b0;
  logic btn_dn = 1'b0;
  logic store_n = 1'b1;
  logic step_up, step_dn, store_req;

  int checks = 0;
  int errors = 0;
  int tick_num = 0;
  int div = 0;
  int cycles = 0;
  string cur_req = "R1";

  int    kind_q[$];
  int    t_q[$];
  string req_q[$];

  always #2.5 clk = ~clk;

  btn_step_ctrl #(.QUAL_TICKS(Q), .HOLD_TICKS(H), .REPEAT_TICKS(RP)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .btn_up(btn_up), .btn_dn(btn_dn), .store_n(store_n),
    .step_up(step_up), .step_dn(step_dn), .store_req(store_req)
  );

  task automatic push_exp(int kind, int t, string req);
    kind_q.push_back(kind);
    t_q.push_back(t);
    req_q.push_back(req);
  endtask

  // Expected pulses of one press started at tick s and held for d ticks
  task automatic expect_press(int kind, int s, int d, string req);
    if (d >= Q) push_exp(kind, s + Q, req);
    if (kind < 2)
      for (int k = 1; H + k * RP <= d; k++) push_exp(kind, s + H + k * RP, req);
  endtask

  task automatic got(int kind);
    checks++;
    if (kind_q.size() == 0) begin
      errors++;
      $display("FAIL %s: pulse kind %0d at tick %0d, expected none", cur_req, kind, tick_num);
    end else begin
      int ek;
      int et;
      string er;
      ek = kind_q.pop_front();
      et = t_q.pop_front();
      er = req_q.pop_front();
      if (ek != kind || et != tick_num) begin
        errors++;
        $display("FAIL %s: pulse kind %0d at tick %0d, expected kind %0d at tick %0d",
                 er, kind, tick_num, ek, et);
      end
    end
  endtask

  // Monitor and tick generator, away from the active edge
  always @(negedge clk) begin
    if (tick) tick_num++;
    if (rst_n) begin
      if (step_up)   got(0);
      if (step_dn)   got(1);
      if (store_req) got(2);
    end
    tick = (div == 3);
    div = (div + 1) % 4;
  end

  task automatic set_pin(int kind, logic v);
    case (kind)
      0: btn_up = v;
      1: btn_dn = v;
      default: store_n = ~v;
    endcase
  endtask

  task automatic align(output int base);
    @(posedge clk iff tick);
    @(negedge clk);
    #1;
    base = tick_num;
  endtask

  task automatic hold_btn(int kind, int dly, int dur);
    if (dly > 0) begin
      repeat (dly) @(posedge clk iff tick);
      @(negedge clk);
      #1;
    end
    set_pin(kind, 1'b1);
    repeat (dur) @(posedge clk iff tick);
    @(negedge clk);
    #1;
    set_pin(kind, 1'b0);
  endtask

  task automatic drained(string req);
    repeat (2) @(posedge clk iff tick);
    @(negedge clk);
    #1;
    checks++;
    if (kind_q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d expected pulses missing, next at tick %0d, expected 0 missing",
               req, kind_q.size(), t_q[0]);
      kind_q.delete();
      t_q.delete();
      req_q.delete();
    end
  endtask

  task automatic solo(int kind, int dur, string req);
    int b;
    cur_req = req;
    align(b);
    expect_press(kind, b, dur, req);
    hold_btn(kind, 0, dur);
    drained(req);
  endtask

  task automatic check_idle_outs(string req);
    checks++;
    if (step_up !== 1'b0 || step_dn !== 1'b0 || store_req !== 1'b0) begin
      errors++;
      $display("FAIL %s: outputs up=%b dn=%b store=%b, expected 0 0 0",
               req, step_up, step_dn, store_req);
    end
  endtask

  initial begin
    int b;
    repeat (3) @(negedge clk);
    check_idle_outs("R1");
    #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_idle_outs("R1");

    // R2: bounce pulses shorter than qualification
    solo(0, 1, "R2");
    solo(0, Q - 1, "R2");
    solo(1, Q - 1, "R2");
    // R3: exactly one step after qualification
    solo(0, Q, "R3");
    solo(0, 10, "R3");
    // R4 / R5: hold into auto-scan
    solo(0, H, "R4");
    solo(0, H + 3 * RP + 2, "R5");
    // R6: down channel
    solo(1, Q, "R6");
    solo(1, H + 2 * RP + 1, "R6");
    // R7: store pin, active low, no repeat
    solo(2, Q - 1, "R7");
    solo(2, Q + 1, "R7");
    solo(2, H + 3 * RP, "R7");

    // R8: two short presses never combine; long press then fresh press
    cur_req = "R8";
    align(b);
    hold_btn(0, 0, Q - 1);
    align(b);
    hold_btn(0, 0, Q - 1);
    drained("R8");
    solo(0, H + RP - 1, "R8");
    solo(0, Q + 2, "R8");

    // R9: both pressed together
    cur_req = "R9";
    align(b);
    fork
      hold_btn(0, 0, H + 3 * RP);
      hold_btn(1, 0, H + 3 * RP);
    join
    drained("R9");

    // R9: down qualified during an up scan suppresses both
    align(b);
    push_exp(0, b + Q, "R9");
    push_exp(0, b + H + 2 * RP, "R9");
    push_exp(0, b + H + 3 * RP, "R9");
    fork
      hold_btn(0, 0, H + 3 * RP + 2);
      hold_btn(1, 10, 20);
    join
    drained("R9");

    check_idle_outs("R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule